// File: doc/BRIEF.md
# Composite Video Horizontal Timing Generator

This block produces the horizontal line timing for an analog television encoder that runs from a clock at four times the colour subcarrier rate. A free-running horizontal counter steps through one line. The counter's value is decoded into flags for each blanking segment (front porch, sync, breezeway, colour burst, back porch), an overall blanking flag and an active-video flag. The block also drives a half-line marker and a composite pulse output, which carries either the normal horizontal sync or, during the vertical interval, equalizing or serration pulses.

Software supplies the standard (525-line or 625-line), a pixel-depth class and three length codes: the active code A (7 bits), the blanking code B (6 bits) and the front-porch code F (6 bits). The block samples these settings at the end of each line and applies them to the line that follows. A configuration flag shows when the programmed active and blanking lengths do not add up to the fixed line period of the selected standard.

Top module: `cvbs_htiming`

## Requirements
- R1: `hcount` is 0 in the first cycle after reset and increments by one each clock. It wraps to 0 after 909 when `pal_sel` was latched as 0, and after 1134 when `pal_sel` was latched as 1.
- R2: Counting from `hcount` 0, the front porch lasts (F+1)*8-7 clocks when `deep_px`=0 and (F+1)*8-5 clocks when `deep_px`=1. The sync follows for 67 clocks (525-line) or 83 clocks (625-line), then the breezeway for 9 or 16 clocks, then the burst for 39 or 44 clocks.
- R3: The back porch starts right after the burst and lasts blanking minus (F+1)*8 minus K clocks. K is 108 or 110 for the 525-line standard and 136 or 138 for the 625-line standard, the larger value applying when `deep_px`=1. So the back porch ends exactly at the end of blanking.
- R4: `blank_on` is high while `hcount` < B*8+6 (525-line) or B*8+7 (625-line). `active_on` is the exact complement of `blank_on`, so active video fills the rest of the line.
- R5: `cfg_err` is high exactly when (A+1)*8 plus the blanking length differs from 910 (525-line) or 1135 (625-line).
- R6: The inputs `pal_sel`, `deep_px`, `act_code`, `blank_code`, `fp_code` and `vert_sel` are sampled only while reset is active and in the last cycle of a line. A change in the middle of a line does not affect any output until the next line.
- R7: `half_mark` pulses for one cycle at `hcount` 0 and again at `hcount` 455 (525-line) or 568 (625-line). In the 625-line standard this splits the line into halves of 568 and 567 clocks.
- R8: When `vert_sel` is latched as 0 (normal) or 3 (reserved), `vpulse` equals `sync_on`.
- R9: When `vert_sel` is latched as 1 (equalizing), `vpulse` is high for 33 clocks (525-line) or 41 clocks (625-line) starting at `hcount` 0, and for the same width starting at the half-line point.
- R10: When `vert_sel` is latched as 2 (serration), `vpulse` is high for 67 clocks (525-line) or 83 clocks (625-line) starting at `hcount` 0, and for the same width starting at the half-line point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the subcarrier rate |
| rst_n | input | 1 | Synchronous active-low reset; settings load while it is low |
| pal_sel | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| deep_px | input | 1 | 0 for 4/8 bpp, 1 for 15/16 bpp |
| act_code | input | 7 | Active length code A |
| blank_code | input | 6 | Blanking length code B |
| fp_code | input | 6 | Front porch code F |
| vert_sel | input | 2 | 0 normal, 1 equalizing, 2 serration, 3 normal |
| hcount | output | 11 | Horizontal position within the line |
| fp_on | output | 1 | Front porch |
| sync_on | output | 1 | Horizontal sync segment |
| brzw_on | output | 1 | Breezeway |
| burst_on | output | 1 | Colour burst |
| bp_on | output | 1 | Back porch |
| blank_on | output | 1 | Horizontal blanking |
| active_on | output | 1 | Active video |
| half_mark | output | 1 | One-cycle pulse at each half-line boundary |
| vpulse | output | 1 | Composite sync or vertical-interval pulse |
| cfg_err | output | 1 | Active plus blanking length does not equal the line period |

## Verification
The hardest case to bring about is a settings change in the middle of a line. It must stay invisible until the wrap and then take effect all at once, including a switch between standards that changes the line period itself. In every line the stimulus drives the next line's settings only in the line's final cycle. At a random point inside most lines it first scrambles every input to random values, so any sampling outside the wrap cycle corrupts the segment edges of the current line. Directed lines cover the shortest possible front porch in both depth classes, a near-empty back porch, each vertical mode in both standards, and an inconsistent length pair.

// File: rtl/htim_pkg.sv
package htim_pkg;
   typedef enum logic [1:0] {
      VM_NORMAL = 2'd0,
      VM_EQUAL  = 2'd1,
      VM_SERR   = 2'd2,
      VM_RSVD   = 2'd3
   } vmode_e;

   localparam int LINE_525  = 910;
   localparam int LINE_625  = 1135;
   localparam int HALF_525  = 455;
   localparam int HALF_625  = 568;
   localparam int SYNC_525  = 67;
   localparam int SYNC_625  = 83;
   localparam int BRZW_525  = 9;
   localparam int BRZW_625  = 16;
   localparam int BURST_525 = 39;
   localparam int BURST_625 = 44;
   localparam int EQW_525   = 33;
   localparam int EQW_625   = 41;
   localparam int SERW_525  = 67;
   localparam int SERW_625  = 83;
   localparam int BOFF_525  = 6;
   localparam int BOFF_625  = 7;
   localparam int FP_TRIM_STD  = 7;
   localparam int FP_TRIM_DEEP = 5;

   function automatic int by_std(input logic pal, input int v525, input int v625);
      return pal ? v625 : v525;
   endfunction
endpackage

// File: rtl/htim_cfg_reg.sv
module htim_cfg_reg #(
   parameter int AW = 7,
   parameter int BW = 6,
   parameter int FW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          pal_i,
   input  logic          deep_i,
   input  logic [AW-1:0] act_i,
   input  logic [BW-1:0] blk_i,
   input  logic [FW-1:0] fp_i,
   input  logic [1:0]    vm_i,
   output logic          pal_q,
   output logic          deep_q,
   output logic [AW-1:0] act_q,
   output logic [BW-1:0] blk_q,
   output logic [FW-1:0] fp_q,
   output logic [1:0]    vm_q
);
   // Settings are taken while reset is held and at the line wrap only.
   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         pal_q  <= pal_i;
         deep_q <= deep_i;
         act_q  <= act_i;
         blk_q  <= blk_i;
         fp_q   <= fp_i;
         vm_q   <= vm_i;
      end
   end
endmodule

// File: rtl/htim_bounds.sv
module htim_bounds
   import htim_pkg::*;
#(
   parameter int CW = 11,
   parameter int AW = 7,
   parameter int BW = 6,
   parameter int FW = 6
) (
   input  logic          pal,
   input  logic          deep,
   input  logic [AW-1:0] act,
   input  logic [BW-1:0] blk,
   input  logic [FW-1:0] fp,
   output logic [CW:0]   e_fp,
   output logic [CW:0]   e_sync,
   output logic [CW:0]   e_brzw,
   output logic [CW:0]   e_burst,
   output logic [CW:0]   e_blank,
   output logic [CW-1:0] last_h,
   output logic [CW-1:0] half_h,
   output logic          err
);
   localparam int SW = CW + 1;

   logic [SW-1:0] fp_span, act_span, period;

   assign fp_span  = ({{(SW-FW){1'b0}}, fp} + SW'(1)) << 3;
   assign act_span = ({{(SW-AW){1'b0}}, act} + SW'(1)) << 3;
   assign period   = SW'(by_std(pal, LINE_525, LINE_625));

   // Edges are cumulative end positions of each blanking segment.
   assign e_fp    = fp_span - SW'(deep ? FP_TRIM_DEEP : FP_TRIM_STD);
   assign e_sync  = e_fp   + SW'(by_std(pal, SYNC_525,  SYNC_625));
   assign e_brzw  = e_sync + SW'(by_std(pal, BRZW_525,  BRZW_625));
   assign e_burst = e_brzw + SW'(by_std(pal, BURST_525, BURST_625));
   assign e_blank = ({{(SW-BW){1'b0}}, blk} << 3) + SW'(by_std(pal, BOFF_525, BOFF_625));

   assign last_h = CW'(period - SW'(1));
   assign half_h = CW'(by_std(pal, HALF_525, HALF_625));
   assign err    = (act_span + e_blank) != period;
endmodule

// File: rtl/htim_line_ctr.sv
module htim_line_ctr #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] last_h,
   output logic [CW-1:0] h,
   output logic          wrap
);
   assign wrap = (h == last_h);

   always_ff @(posedge clk) begin
      if (!rst_n || wrap) h <= '0;
      else                h <= h + CW'(1);
   end
endmodule

// File: rtl/htim_decode.sv
module htim_decode
   import htim_pkg::*;
#(
   parameter int CW = 11
) (
   input  logic [CW-1:0] h,
   input  logic          pal,
   input  logic [1:0]    vm,
   input  logic [CW:0]   e_fp,
   input  logic [CW:0]   e_sync,
   input  logic [CW:0]   e_brzw,
   input  logic [CW:0]   e_burst,
   input  logic [CW:0]   e_blank,
   input  logic [CW-1:0] half_h,
   output logic          fp_on,
   output logic          sync_on,
   output logic          brzw_on,
   output logic          burst_on,
   output logic          bp_on,
   output logic          blank_on,
   output logic          active_on,
   output logic          half_mark,
   output logic          vpulse
);
   logic [CW:0] hx, hh, eqw, serw;
   logic        in_eq, in_serr;

   assign hx = {1'b0, h};
   assign hh = {1'b0, half_h};

   assign fp_on     = hx < e_fp;
   assign sync_on   = (hx >= e_fp)    && (hx < e_sync);
   assign brzw_on   = (hx >= e_sync)  && (hx < e_brzw);
   assign burst_on  = (hx >= e_brzw)  && (hx < e_burst);
   assign bp_on     = (hx >= e_burst) && (hx < e_blank);
   assign blank_on  = hx < e_blank;
   assign active_on = !blank_on;

   assign half_mark = (h == '0) || (h == half_h);

   assign eqw  = (CW+1)'(by_std(pal, EQW_525,  EQW_625));
   assign serw = (CW+1)'(by_std(pal, SERW_525, SERW_625));

   assign in_eq   = (hx < eqw)  || ((hx >= hh) && (hx < hh + eqw));
   assign in_serr = (hx < serw) || ((hx >= hh) && (hx < hh + serw));

   always_comb begin
      case (vmode_e'(vm))
         VM_EQUAL: vpulse = in_eq;
         VM_SERR:  vpulse = in_serr;
         default:  vpulse = sync_on;
      endcase
   end
endmodule

// File: rtl/cvbs_htiming.sv
module cvbs_htiming #(
   parameter int CW = 11,
   parameter int AW = 7,
   parameter int BW = 6,
   parameter int FW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pal_sel,
   input  logic          deep_px,
   input  logic [AW-1:0] act_code,
   input  logic [BW-1:0] blank_code,
   input  logic [FW-1:0] fp_code,
   input  logic [1:0]    vert_sel,
   output logic [CW-1:0] hcount,
   output logic          fp_on,
   output logic          sync_on,
   output logic          brzw_on,
   output logic          burst_on,
   output logic          bp_on,
   output logic          blank_on,
   output logic          active_on,
   output logic          half_mark,
   output logic          vpulse,
   output logic          cfg_err
);
   generate
      if ((1 << CW) < htim_pkg::LINE_625) begin : g_cw_chk
         $error("CW too narrow for the longest line");
      end
      if (AW + 3 > CW || BW + 3 >= CW || FW + 3 >= CW) begin : g_field_chk
         $error("code fields too wide for CW");
      end
   endgenerate

   logic          l_pal, l_deep, wrap;
   logic [AW-1:0] l_act;
   logic [BW-1:0] l_blk;
   logic [FW-1:0] l_fp;
   logic [1:0]    l_vm;
   logic [CW:0]   e_fp, e_sync, e_brzw, e_burst, e_blank;
   logic [CW-1:0] last_h, half_h;

   htim_cfg_reg #(.AW(AW), .BW(BW), .FW(FW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(wrap),
      .pal_i(pal_sel), .deep_i(deep_px), .act_i(act_code),
      .blk_i(blank_code), .fp_i(fp_code), .vm_i(vert_sel),
      .pal_q(l_pal), .deep_q(l_deep), .act_q(l_act),
      .blk_q(l_blk), .fp_q(l_fp), .vm_q(l_vm)
   );

   htim_bounds #(.CW(CW), .AW(AW), .BW(BW), .FW(FW)) u_bnd (
      .pal(l_pal), .deep(l_deep), .act(l_act), .blk(l_blk), .fp(l_fp),
      .e_fp(e_fp), .e_sync(e_sync), .e_brzw(e_brzw), .e_burst(e_burst),
      .e_blank(e_blank), .last_h(last_h), .half_h(half_h), .err(cfg_err)
   );

   htim_line_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .last_h(last_h), .h(hcount), .wrap(wrap)
   );

   htim_decode #(.CW(CW)) u_dec (
      .h(hcount), .pal(l_pal), .vm(l_vm),
      .e_fp(e_fp), .e_sync(e_sync), .e_brzw(e_brzw), .e_burst(e_burst),
      .e_blank(e_blank), .half_h(half_h),
      .fp_on(fp_on), .sync_on(sync_on), .brzw_on(brzw_on),
      .burst_on(burst_on), .bp_on(bp_on), .blank_on(blank_on),
      .active_on(active_on), .half_mark(half_mark), .vpulse(vpulse)
   );
endmodule

// File: rtl/cvbs_htiming_chk.sv
module cvbs_htiming_chk
   import htim_pkg::*;
#(
   parameter int CW = 11,
   parameter int LW = 23
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] hcount,
   input logic          lat_pal,
   input logic [1:0]    lat_vm,
   input logic [LW-1:0] lat_vec,
   input logic          fp_on,
   input logic          sync_on,
   input logic          brzw_on,
   input logic          burst_on,
   input logic          bp_on,
   input logic          blank_on,
   input logic          active_on,
   input logic          half_mark,
   input logic          vpulse
);
   logic [CW-1:0] last_h, half_h;
   assign last_h = CW'(by_std(lat_pal, LINE_525, LINE_625) - 1);
   assign half_h = CW'(by_std(lat_pal, HALF_525, HALF_625));

   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hcount == last_h) |=> (hcount == '0));

   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hcount < last_h) |=> (hcount == $past(hcount) + CW'(1)));

   p_seg_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fp_on, sync_on, brzw_on, burst_on, bp_on, active_on}));

   p_blank_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      blank_on != active_on);

   p_hold_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hcount != last_h) |=> $stable(lat_vec));

   p_half_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
      half_mark |-> (hcount == '0 || hcount == half_h));

   p_norm_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_vm == 2'd0 || lat_vm == 2'd3) |-> (vpulse == sync_on));
endmodule

bind cvbs_htiming cvbs_htiming_chk #(.CW(CW), .LW(AW + BW + FW + 4)) u_chk (
   .clk(clk), .rst_n(rst_n), .hcount(hcount),
   .lat_pal(l_pal), .lat_vm(l_vm),
   .lat_vec({l_pal, l_deep, l_act, l_blk, l_fp, l_vm}),
   .fp_on(fp_on), .sync_on(sync_on), .brzw_on(brzw_on),
   .burst_on(burst_on), .bp_on(bp_on), .blank_on(blank_on),
   .active_on(active_on), .half_mark(half_mark), .vpulse(vpulse)
);

// File: tb/tb_cvbs_htiming.sv
module tb_cvbs_htiming;
   localparam int CW = 11, AW = 7, BW = 6, FW = 6;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          pal_sel = 1'b0, deep_px = 1'b0;
   logic [AW-1:0] act_code = '0;
   logic [BW-1:0] blank_code = '0;
   logic [FW-1:0] fp_code = '0;
   logic [1:0]    vert_sel = '0;
   logic [CW-1:0] hcount;
   logic fp_on, sync_on, brzw_on, burst_on, bp_on, blank_on, active_on;
   logic half_mark, vpulse, cfg_err;

   cvbs_htiming #(.CW(CW), .AW(AW), .BW(BW), .FW(FW)) dut (.*);

   int  n_vec = 0, n_bad = 0;
   bit  chk_en = 1'b0;

   // Bench-side model of the latched settings and position
   int  m_h = 0, m_a = 0, m_b = 0, m_f = 0, m_vm = 0;
   bit  m_pal = 1'b0, m_deep = 1'b0;

   function automatic int line_len(bit p); return p ? 1135 : 910; endfunction

   always @(posedge clk) begin
      if (!rst_n || m_h == line_len(m_pal) - 1) begin
         m_h = 0; m_pal = pal_sel; m_deep = deep_px; m_a = int'(act_code);
         m_b = int'(blank_code); m_f = int'(fp_code); m_vm = int'(vert_sel);
      end else m_h = m_h + 1;
   end

   task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %0d exp %0d (h=%0d pal=%0d vm=%0d)",
                  tag, got, exp, m_h, m_pal, m_vm);
      end
   endtask

   always @(negedge clk) begin
      if (chk_en) begin
         int fpl, syl, bzl, bul, k, blank, bpl, half, ew, sw, e1, e2, e3, e4, e5;
         bit exp_v;
         fpl   = (m_f + 1) * 8 - (m_deep ? 5 : 7);
         syl   = m_pal ? 83 : 67;
         bzl   = m_pal ? 16 : 9;
         bul   = m_pal ? 44 : 39;
         k     = m_pal ? (m_deep ? 138 : 136) : (m_deep ? 110 : 108);
         blank = m_b * 8 + (m_pal ? 7 : 6);
         bpl   = blank - (m_f + 1) * 8 - k;
         half  = m_pal ? 568 : 455;
         ew    = m_pal ? 41 : 33;
         sw    = m_pal ? 83 : 67;
         e1 = fpl; e2 = e1 + syl; e3 = e2 + bzl; e4 = e3 + bul; e5 = e4 + bpl;
         check("R1 hcount", 16'(hcount), 16'(m_h));
         check("R2 fp_on",    16'(fp_on),    16'(m_h < e1));
         check("R2 sync_on",  16'(sync_on),  16'(m_h >= e1 && m_h < e2));
         check("R2 brzw_on",  16'(brzw_on),  16'(m_h >= e2 && m_h < e3));
         check("R2 burst_on", 16'(burst_on), 16'(m_h >= e3 && m_h < e4));
         check("R3 bp_on",    16'(bp_on),    16'(m_h >= e4 && m_h < e5));
         check("R4 blank_on", 16'(blank_on), 16'(m_h < blank));
         check("R4 active_on",16'(active_on),16'(m_h >= blank));
         check("R5 cfg_err",  16'(cfg_err),  16'((m_a + 1) * 8 + blank != line_len(m_pal)));
         check("R7 half_mark",16'(half_mark),16'(m_h == 0 || m_h == half));
         case (m_vm)
            1: begin exp_v = (m_h < ew) || (m_h >= half && m_h < half + ew);
                  check("R9 vpulse", 16'(vpulse), 16'(exp_v)); end
            2: begin exp_v = (m_h < sw) || (m_h >= half && m_h < half + sw);
                  check("R10 vpulse", 16'(vpulse), 16'(exp_v)); end
            default: check("R8 vpulse", 16'(vpulse), 16'(m_h >= e1 && m_h < e2));
         endcase
      end
   end

   // Drive settings for one line; scramble mid-line to test R6 sampling.
   task automatic do_line(bit p, bit d, int a, int b, int f, int vm, bit scramble);
      pal_sel = p; deep_px = d; act_code = AW'(a); blank_code = BW'(b);
      fp_code = FW'(f); vert_sel = 2'(vm);
      @(negedge clk);
      while (m_h != 0) @(negedge clk);
      if (scramble) begin
         repeat ($urandom_range(5, 850)) @(negedge clk);
         pal_sel = 1'($urandom); deep_px = 1'($urandom); act_code = AW'($urandom);
         blank_code = BW'($urandom); fp_code = FW'($urandom); vert_sel = 2'($urandom);
      end
      while (m_h != line_len(m_pal) - 1) @(negedge clk);
   endtask

   task automatic rand_line();
      bit p, d; int a, b, f, k, off, fmax;
      p = 1'($urandom); d = 1'($urandom);
      b = p ? $urandom_range(20, 40) : $urandom_range(16, 40);
      a = (p ? 140 : 112) - b;
      off = p ? 7 : 6;
      k = p ? (d ? 138 : 136) : (d ? 110 : 108);
      fmax = (b * 8 + off - k - 1) / 8 - 1;
      f = $urandom_range(0, fmax);
      if ($urandom_range(0, 9) == 0) a = (a + 3 > 127) ? a - 4 : a + 3;
      do_line(p, d, a, b, f, $urandom_range(0, 3), $urandom_range(0, 3) != 0);
   endtask

   initial begin
      void'($urandom(32'd1357));
      pal_sel = 0; deep_px = 0; act_code = 7'd92; blank_code = 6'd20; fp_code = 6'd0;
      @(posedge clk);
      chk_en = 1'b1;               // reset state checks (R1)
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      do_line(0, 0, 92, 20, 0, 0, 0);   // shortest front porch, 4/8 bpp (R2)
      do_line(1, 1, 115, 25, 0, 1, 0);  // 625-line deep, equalizing (R9)
      do_line(0, 1, 92, 20, 0, 2, 1);   // serration, scrambled (R10, R6)
      do_line(1, 0, 115, 25, 2, 3, 1);  // reserved mode acts normal (R8)
      do_line(0, 0, 50, 20, 3, 0, 0);   // inconsistent lengths (R5)
      do_line(0, 0, 92, 20, 6, 1, 0);   // near-empty back porch (R3)
      do_line(1, 0, 140 - 63, 63, 8, 2, 1); // largest blanking (R4)
      for (int i = 0; i < 50; i++) rand_line();
      @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #760000;
      n_bad++;
      $display("FAIL R1 watchdog: run got >190000 cycles exp fewer");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule